// File: doc/BRIEF.md
# Latency-Timed Target Channel

This block connects two simulated units that each step their own target clock at whatever host rate suits them. Seen in target time, it behaves like a plain delay line: each target cycle the sending unit hands in one token, and the token it handed in a fixed number of target cycles earlier comes out at the receiving unit. Seen in host time, it is an elastic queue. Each accepted enqueue marks one producer target cycle, and each accepted dequeue marks one consumer target cycle. Either side may stall or run ahead within the limits the queue imposes.

Every token carries a valid flag next to its data. A producer target cycle with nothing to send still enqueues a token, with the flag cleared (a bubble). This keeps the count of tokens equal to the count of target cycles. Reset places LATENCY bubble tokens in the queue. As a result, the first token the producer sends is the one the consumer takes on its target cycle number LATENCY. The queue holds LATENCY+SLACK entries, so the producer can run up to SLACK target cycles ahead of the consumer.

Top module: `ltc_channel`

## Requirements
- R1: In the cycle after a synchronous reset, prod_ready is 1, cons_ready is 1 and cons_valid is 0.
- R2: The first LATENCY dequeues after reset present bubble tokens: cons_valid is 0 and cons_data is 0.
- R3: The token from the producer's n-th accepted enqueue (counting from 0) is presented on the consumer's accepted dequeue number n+LATENCY, with its data unchanged. Tokens leave in the order they entered.
- R4: A token enqueued with prod_valid=0 leaves with cons_valid=0. A token enqueued with prod_valid=1 leaves with cons_valid=1.
- R5: prod_ready is 0 exactly when LATENCY+SLACK tokens are held. While prod_ready is 0, prod_enq is ignored.
- R6: cons_ready is 0 exactly when no token is held, and cons_valid is then 0. While cons_ready is 0, cons_deq is ignored.
- R7: An accepted enqueue and an accepted dequeue in the same host cycle leave the occupancy, and so both ready outputs, unchanged.
- R8: prod_ready and cons_ready are registered. They reflect an accepted operation from the host cycle after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rst | input | 1 | Synchronous active-high reset; preloads LATENCY bubbles |
| prod_enq | input | 1 | Producer ends a target cycle and pushes one token |
| prod_valid | input | 1 | Valid flag of the pushed token (0 = bubble) |
| prod_data | input | DATA_W | Data of the pushed token |
| prod_ready | output | 1 | Room for one more token |
| cons_deq | input | 1 | Consumer takes the head token for its target cycle |
| cons_valid | output | 1 | Valid flag of the head token |
| cons_data | output | DATA_W | Data of the head token |
| cons_ready | output | 1 | At least one token is held |

## Verification
The ready outputs respond to an accepted operation one host cycle after that operation's clock edge. The head token is also visible one cycle after the edge that wrote or popped it. The bench therefore drives inputs on a falling edge and compares all outputs on the next falling edge against a reference queue. That queue is updated only with the operations the design accepted at the edge in between. On each accepted dequeue, the bench checks the producer index of a valid token against the consumer's dequeue index minus LATENCY. Directed fill, drain and simultaneous phases are followed by random host rates for the two sides.

// File: rtl/ltc_pkg.sv
package ltc_pkg;
  function automatic int cnt_bits(input int n);
    return $clog2(n + 1);
  endfunction

  function automatic int ptr_bits(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/ltc_occupancy.sv
module ltc_occupancy #(
  parameter int DEPTH = 5,
  parameter int INIT  = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic enq_ok,
  input  logic deq_ok,
  output logic room,
  output logic avail
);
  localparam int CW = ltc_pkg::cnt_bits(DEPTH);
  localparam logic [CW-1:0] FULLV = CW'(DEPTH);
  localparam logic [CW-1:0] INITV = CW'(INIT);

  logic [CW-1:0] count, count_n;

  always_comb begin
    count_n = count;
    if (enq_ok && !deq_ok) count_n = count + 1'b1;
    else if (deq_ok && !enq_ok) count_n = count - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= INITV;
      room  <= (INITV != FULLV);
      avail <= (INITV != '0);
    end else begin
      count <= count_n;
      room  <= (count_n != FULLV);
      avail <= (count_n != '0);
    end
  end
endmodule

// File: rtl/ltc_store.sv
module ltc_store #(
  parameter int TW    = 9,
  parameter int DEPTH = 5,
  parameter int INIT  = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [TW-1:0] wr_tok,
  input  logic          rd_en,
  output logic [TW-1:0] rd_tok
);
  localparam int PW = ltc_pkg::ptr_bits(DEPTH);
  localparam logic [PW-1:0] LAST   = PW'(DEPTH - 1);
  localparam logic [PW-1:0] WR_RST = PW'(INIT % DEPTH);

  logic [TW-1:0] mem [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_ptr] <= wr_tok;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= WR_RST;
      rd_ptr <= '0;
    end else begin
      if (wr_en) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
      if (rd_en) rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
    end
  end

  assign rd_tok = mem[rd_ptr];
endmodule

// File: rtl/ltc_preload.sv
module ltc_preload #(
  parameter int INIT = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic deq_ok,
  output logic masked
);
  localparam int BW = ltc_pkg::cnt_bits(INIT);
  localparam logic [BW-1:0] INITV = BW'(INIT);

  logic [BW-1:0] left;

  always_ff @(posedge clk) begin
    if (rst) left <= INITV;
    else if (deq_ok && left != '0) left <= left - 1'b1;
  end

  assign masked = (left != '0);
endmodule

// File: rtl/ltc_channel.sv
module ltc_channel #(
  parameter int DATA_W  = 8,
  parameter int LATENCY = 3,
  parameter int SLACK   = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              prod_enq,
  input  logic              prod_valid,
  input  logic [DATA_W-1:0] prod_data,
  output logic              prod_ready,
  input  logic              cons_deq,
  output logic              cons_valid,
  output logic [DATA_W-1:0] cons_data,
  output logic              cons_ready
);
  localparam int DEPTH = LATENCY + SLACK;
  localparam int TW    = DATA_W + 1;

  logic          enq_ok, deq_ok, masked;
  logic [TW-1:0] head;

  assign enq_ok = prod_enq && prod_ready;
  assign deq_ok = cons_deq && cons_ready;

  ltc_occupancy #(.DEPTH(DEPTH), .INIT(LATENCY)) u_occ (
    .clk(clk), .rst(rst), .enq_ok(enq_ok), .deq_ok(deq_ok),
    .room(prod_ready), .avail(cons_ready)
  );

  ltc_store #(.TW(TW), .DEPTH(DEPTH), .INIT(LATENCY)) u_store (
    .clk(clk), .rst(rst), .wr_en(enq_ok), .wr_tok({prod_valid, prod_data}),
    .rd_en(deq_ok), .rd_tok(head)
  );

  generate
    if (LATENCY > 0) begin : g_pre
      ltc_preload #(.INIT(LATENCY)) u_pre (
        .clk(clk), .rst(rst), .deq_ok(deq_ok), .masked(masked)
      );
    end else begin : g_nopre
      assign masked = 1'b0;
    end
  endgenerate

  assign cons_valid = cons_ready && !masked && head[DATA_W];
  assign cons_data  = (cons_ready && !masked) ? head[DATA_W-1:0] : '0;
endmodule

// File: rtl/ltc_channel_chk.sv
module ltc_channel_chk #(
  parameter int DATA_W  = 8,
  parameter int LATENCY = 3,
  parameter int SLACK   = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              prod_enq,
  input logic              prod_valid,
  input logic [DATA_W-1:0] prod_data,
  input logic              prod_ready,
  input logic              cons_deq,
  input logic              cons_valid,
  input logic [DATA_W-1:0] cons_data,
  input logic              cons_ready
);
  localparam int DEPTH = LATENCY + SLACK;
  localparam int OW = ltc_pkg::cnt_bits(DEPTH);
  localparam int QW = ltc_pkg::cnt_bits(LATENCY);

  logic [OW-1:0] occ;
  logic [QW-1:0] deqs;
  logic e_ok, d_ok;

  assign e_ok = prod_enq && prod_ready;
  assign d_ok = cons_deq && cons_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      occ  <= OW'(LATENCY);
      deqs <= '0;
    end else begin
      occ <= occ + OW'(e_ok) - OW'(d_ok);
      if (d_ok && deqs != QW'(LATENCY)) deqs <= deqs + 1'b1;
    end
  end

  AST_FULL_BLOCKS: assert property (@(posedge clk) disable iff (rst)
    (occ == OW'(DEPTH)) |-> !prod_ready);  // R5
  AST_ROOM_WHEN_NOT_FULL: assert property (@(posedge clk) disable iff (rst)
    (occ != OW'(DEPTH)) |-> prod_ready);  // R5
  AST_EMPTY_BLOCKS: assert property (@(posedge clk) disable iff (rst)
    (occ == '0) |-> (!cons_ready && !cons_valid));  // R6
  AST_PRELOAD_BUBBLE: assert property (@(posedge clk) disable iff (rst)
    (deqs != QW'(LATENCY)) |-> (!cons_valid && cons_data == '0));  // R2
  AST_SIMUL_KEEPS: assert property (@(posedge clk) disable iff (rst)
    (e_ok && d_ok) |=> ($stable(prod_ready) && $stable(cons_ready)));  // R7
  AST_FREE_SLOT: assert property (@(posedge clk) disable iff (rst)
    (d_ok && !e_ok) |=> prod_ready);  // R8
  AST_NEW_TOKEN: assert property (@(posedge clk) disable iff (rst)
    (e_ok && !d_ok) |=> cons_ready);  // R8
endmodule

bind ltc_channel ltc_channel_chk #(.DATA_W(DATA_W), .LATENCY(LATENCY), .SLACK(SLACK)) u_chk (
  .clk(clk), .rst(rst), .prod_enq(prod_enq), .prod_valid(prod_valid),
  .prod_data(prod_data), .prod_ready(prod_ready), .cons_deq(cons_deq),
  .cons_valid(cons_valid), .cons_data(cons_data), .cons_ready(cons_ready)
);

// File: tb/ltc_channel_test.sv
module ltc_channel_test;
  localparam int DATA_W = 8, LATENCY = 3, SLACK = 2, DEPTH = LATENCY + SLACK;

  logic clk = 1'b0, rst = 1'b1;
  logic prod_enq = 0, prod_valid = 0, cons_deq = 0;
  logic [DATA_W-1:0] prod_data = '0;
  logic prod_ready, cons_valid, cons_ready;
  logic [DATA_W-1:0] cons_data;

  int checks = 0, fails = 0, enq_n = 0, deq_n = 0;
  bit done = 0;
  logic [DATA_W:0] mq[$];
  int mi[$];

  always #10 clk = ~clk;  // 50 MHz

  ltc_channel #(.DATA_W(DATA_W), .LATENCY(LATENCY), .SLACK(SLACK)) uut (
    .clk(clk), .rst(rst), .prod_enq(prod_enq), .prod_valid(prod_valid),
    .prod_data(prod_data), .prod_ready(prod_ready), .cons_deq(cons_deq),
    .cons_valid(cons_valid), .cons_data(cons_data), .cons_ready(cons_ready)
  );

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic bit exp_room();  return mq.size() != DEPTH; endfunction
  function automatic bit exp_avail(); return mq.size() != 0;     endfunction

  task automatic compare();
    chk("R5 prod_ready", prod_ready, exp_room());
    chk("R6 cons_ready", cons_ready, exp_avail());
    if (mq.size() != 0) begin
      chk("R4 cons_valid", cons_valid, mq[0][DATA_W]);
      chk("R3 cons_data", cons_data, mq[0][DATA_W-1:0]);
    end else chk("R6 cons_valid empty", cons_valid, 0);
  endtask

  task automatic step(input bit e, input bit v, input logic [DATA_W-1:0] d, input bit q);
    bit acc_e, acc_d;
    compare();
    prod_enq = e; prod_valid = v; prod_data = d; cons_deq = q;
    acc_e = e && prod_ready;
    acc_d = q && cons_ready;
    if (acc_d) begin
      if (mq[0][DATA_W]) chk("R3 token timing", mi[0] + LATENCY, deq_n);
      void'(mq.pop_front());
      void'(mi.pop_front());
      deq_n++;
    end
    if (acc_e) begin
      mq.push_back({v, d});
      mi.push_back(enq_n);
      enq_n++;
    end
    @(negedge clk);
    prod_enq = 0; cons_deq = 0;
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      summary();
    end
  end

  initial begin
    void'($urandom(32'd4711));
    for (int i = 0; i < LATENCY; i++) begin
      mq.push_back('0);
      mi.push_back(-LATENCY + i);
    end
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1: state after reset
    chk("R1 prod_ready", prod_ready, 1);
    chk("R1 cons_ready", cons_ready, 1);
    chk("R1 cons_valid", cons_valid, 0);
    // R5: fill to full, then an extra enqueue is ignored
    for (int i = 0; i < SLACK; i++) step(1, 1, 8'(8'hA0 + i), 0);
    chk("R5 full", prod_ready, 0);
    step(1, 1, 8'hEE, 0);
    // R2: drain preload bubbles and filled tokens, R6 extra deq on empty
    for (int i = 0; i < LATENCY; i++) begin
      chk("R2 bubble valid", cons_valid, 0);
      chk("R2 bubble data", cons_data, 0);
      step(0, 0, 0, 1);
    end
    for (int i = 0; i < SLACK; i++) step(0, 0, 0, 1);
    chk("R6 empty", cons_ready, 0);
    step(0, 0, 0, 1);
    step(1, 1, 8'h55, 0);  // accepted after empty, not the ignored data
    // R7: simultaneous enqueue and dequeue; R4 bubble in the middle
    for (int i = 0; i < 4; i++) begin
      step(1, i != 2, 8'(8'h30 + i), 1);
      chk("R7 occupancy held", {prod_ready, cons_ready}, 2'b11);
    end
    // R8: ready flips one cycle after the filling enqueue
    while (mq.size() < DEPTH - 1) step(1, 1, 8'h77, 0);
    step(1, 0, 8'h78, 0);
    chk("R8 prod_ready drop", prod_ready, 0);
    // random host rates for both sides
    for (int ph = 0; ph < 6; ph++) begin
      int pe = 20 + 15 * ph, pd = 95 - 15 * ph;
      for (int c = 0; c < 600; c++)
        step(($urandom % 100) < pe, $urandom % 2, 8'($urandom), ($urandom % 100) < pd);
    end
    compare();
    done = 1;
    summary();
  end
endmodule